// File: doc/BRIEF.md
# Position-Priority Bus Ownership Chain

This block chooses which of several devices on a shared bus may act as master. No central decision unit is involved. Each device owns one cell. The cells form a line, and a single permission signal travels along it from left to right. A cell with a pending request blocks the permission for every cell to its right. The device nearest the left end therefore has the strongest claim. A shared occupancy line is the OR of the occupancy flags of all cells. A cell may take the bus only when the permission reaches it and the occupancy line is low.

After a cell wins, it sets its occupancy flag and stops blocking the permission. Waiting cells further along the line can then settle which of them goes next while the current transfer is still in progress. The owner keeps the bus as long as its request stays high. Dropping the request clears its flag on the next clock edge. On the edge after that, the leftmost waiting cell takes over.

The cells and the occupancy OR are generated from a parameter that sets how many devices share the bus. Cell 0 is the leftmost device. Its incoming permission is tied high.

Top module: `busChainArbiter`

## Requirements
- R1: While reset is held, and after it is released with no requests, `busGrant` is all zeros and `busBusy` is low.
- R2: When the occupancy line is low and requests are pending, the next edge grants the bus to the pending request with the lowest index. Bit 0 of `busReq` and `busGrant` belongs to the leftmost device.
- R3: No more than one bit of `busGrant` is ever high. `busBusy` is high exactly when one bit of `busGrant` is high.
- R4: No cell gains a grant on an edge where the occupancy line was high before that edge. A higher-priority request that arrives while another cell owns the bus does not take the bus away from the owner.
- R5: An owner whose request stays high keeps its grant on every following edge.
- R6: When an owner's request is low at an edge, its grant and `busBusy` go low after that edge. That same edge grants the bus to no cell, including the releasing one.
- R7: A cell that waited during a transfer gains the grant on the first edge at which the occupancy line is low. This is the edge right after the release edge, and the waiter must be the leftmost pending request.
- R8: `busChainOut` (the permission leaving the rightmost cell) is low exactly when some cell is requesting without owning the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | NUM_DEV | Request from each device, bit 0 leftmost |
| busGrant | output | NUM_DEV | Registered ownership flag for each device |
| busBusy | output | 1 | Shared occupancy line, OR of all ownership flags |
| busChainOut | output | 1 | Permission signal leaving the rightmost cell |

## Verification
The assertions are checked on every clock cycle. They cover the following behaviours:
- no more than one owner exists at any time;
- no cell takes ownership unless the occupancy line was low on the previous cycle;
- an owner keeps the bus while its request is held;
- an owner lets go after its request drops;
- every new owner is the leftmost requester of the previous cycle.

Some behaviours appear only in the bench scenarios:
- the one idle cycle between a release and the next grant;
- a late high-priority request that is refused during a transfer and then served at the handover;
- the permission output that tells whether any cell is still waiting.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Per-cell strobes sent from the decision logic to the ownership datapath.
  typedef struct packed {
    logic take;  // cell becomes owner at the next edge
    logic drop;  // cell gives up ownership at the next edge
  } cellStb_t;
endpackage

// File: rtl/arb_link.sv
// One position in the permission chain: it blocks the permission while its
// device is waiting and lets it through otherwise.
module arb_link (
  input  logic linkIn,
  input  logic linkReq,
  input  logic linkOwner,
  output logic linkOut
);
  logic waiting;
  assign waiting = linkReq & ~linkOwner;
  assign linkOut = linkIn & ~waiting;
endmodule

// File: rtl/arb_win_ctl.sv
// Decision logic: turns the chain and occupancy state into take and drop strobes.
module arb_win_ctl
  import arb_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic [NUM_DEV-1:0] reqVec,
  input  logic [NUM_DEV-1:0] permVec,
  input  logic [NUM_DEV-1:0] ownerVec,
  input  logic               busyLine,
  output cellStb_t [NUM_DEV-1:0] stbVec
);
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cell
    always_comb begin
      stbVec[i].take = reqVec[i] & permVec[i] & ~busyLine & ~ownerVec[i];
      stbVec[i].drop = ownerVec[i] & ~reqVec[i];
    end
  end
endmodule

// File: rtl/arb_chain_dp.sv
// Datapath: ownership flops, permission chain and occupancy OR.
module arb_chain_dp
  import arb_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] reqVec,
  input  cellStb_t [NUM_DEV-1:0] stbVec,
  output logic [NUM_DEV-1:0] permVec,
  output logic [NUM_DEV-1:0] ownerVec,
  output logic               busyLine,
  output logic               chainTail
);
  logic [NUM_DEV-1:0] passVec;

  // Cell 0 is leftmost; its incoming permission is tied high.
  assign permVec[0] = 1'b1;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_link
    arb_link u_link (
      .linkIn   (permVec[i]),
      .linkReq  (reqVec[i]),
      .linkOwner(ownerVec[i]),
      .linkOut  (passVec[i])
    );
    if (i > 0) begin : g_hop
      assign permVec[i] = passVec[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ownerVec[i] <= 1'b0;
      end else if (stbVec[i].take) begin
        ownerVec[i] <= 1'b1;
      end else if (stbVec[i].drop) begin
        ownerVec[i] <= 1'b0;
      end
    end
  end

  assign chainTail = passVec[NUM_DEV-1];
  assign busyLine  = |ownerVec;

  // R3
  single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ownerVec));

  // R4
  idle_before_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(ownerVec & ~$past(ownerVec))) |-> !$past(busyLine));

  // R5
  hold_while_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(ownerVec & reqVec)) |=> ((ownerVec & $past(ownerVec & reqVec)) == $past(ownerVec & reqVec)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(ownerVec & ~reqVec)) |=> (ownerVec == '0));
endmodule

// File: rtl/busChainArbiter.sv
// Thin top: decision logic plus ownership datapath.
module busChainArbiter
  import arb_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] busReq,
  output logic [NUM_DEV-1:0] busGrant,
  output logic               busBusy,
  output logic               busChainOut
);
  cellStb_t [NUM_DEV-1:0] stbVec;
  logic [NUM_DEV-1:0] permVec;
  logic [NUM_DEV-1:0] ownerVec;
  logic               busyLine;

  arb_win_ctl #(.NUM_DEV(NUM_DEV)) u_ctl (
    .reqVec  (busReq),
    .permVec (permVec),
    .ownerVec(ownerVec),
    .busyLine(busyLine),
    .stbVec  (stbVec)
  );

  arb_chain_dp #(.NUM_DEV(NUM_DEV)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (busReq),
    .stbVec   (stbVec),
    .permVec  (permVec),
    .ownerVec (ownerVec),
    .busyLine (busyLine),
    .chainTail(busChainOut)
  );

  assign busGrant = ownerVec;
  assign busBusy  = busyLine;

  // Lowest set bit of the request vector, i.e. the leftmost requester.
  logic [NUM_DEV-1:0] leftReq;
  assign leftReq = busReq & (~busReq + 1'b1);

  // R2
  leftmost_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(busGrant & ~$past(busGrant))) |-> (busGrant == $past(leftReq)));
endmodule

// File: tb/busChainArbiter_bench.sv
module busChainArbiter_bench;
  localparam int N = 4;

  typedef struct {
    logic [N-1:0] grant;
    logic         tail;
    string        tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] busReq = '0;
  logic [N-1:0] busGrant;
  logic         busBusy;
  logic         busChainOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #2 clk = ~clk;  // 250 MHz

  busChainArbiter #(.NUM_DEV(N)) u_busChainArbiter (
    .clk(clk), .rstN(rstN), .busReq(busReq),
    .busGrant(busGrant), .busBusy(busBusy), .busChainOut(busChainOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: applies the request vector for one cycle and queues the result
  // expected after the next rising edge.
  task automatic step(logic [N-1:0] req, logic [N-1:0] expG, logic expTail, string tag);
    expItem_t it;
    @(negedge clk);
    busReq = req;
    it.grant = expG;
    it.tail = expTail;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: checks just after each edge.
  always @(posedge clk) begin
    #1;
    if (rstN && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check({it.tag, " grant"}, 32'(busGrant), 32'(it.grant));
      check({it.tag, " busy R3"}, 32'(busBusy), 32'(|it.grant));
      check({it.tag, " onehot R3"}, 32'($countones(busGrant) <= 1), 32'd1);
      check({it.tag, " chain R8"}, 32'(busChainOut), 32'(it.tail));
    end
  end

  initial begin
    // R1: held in reset with requests present
    busReq = 4'b0101;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset grant", 32'(busGrant), 32'd0);
    check("R1 reset busy", 32'(busBusy), 32'd0);
    @(negedge clk);
    busReq = '0;
    rstN = 1'b1;
    // tail: low when any cell requests without owning
    step(4'b0000, 4'b0000, 1'b1, "R1 idle");
    step(4'b1010, 4'b0010, 1'b0, "R2 leftmost of two");
    step(4'b1011, 4'b0010, 1'b0, "R4 no preemption");
    step(4'b1011, 4'b0010, 1'b0, "R5 hold");
    step(4'b1001, 4'b0000, 1'b0, "R6 release");
    step(4'b1001, 4'b0001, 1'b0, "R7 handover to waiter");
    step(4'b1000, 4'b0000, 1'b0, "R6 release cell0");
    step(4'b1000, 4'b1000, 1'b1, "R7 rightmost gets bus");
    step(4'b1111, 4'b1000, 1'b0, "R4 all request");
    step(4'b0111, 4'b0000, 1'b0, "R6 release cell3");
    step(4'b0111, 4'b0001, 1'b0, "R2 leftmost of three");
    step(4'b0110, 4'b0000, 1'b0, "R6 release cell0 again");
    step(4'b0110, 4'b0010, 1'b0, "R7 next waiter");
    step(4'b0000, 4'b0000, 1'b1, "R6 all drop");
    step(4'b0100, 4'b0100, 1'b1, "R2 single request");
    step(4'b0000, 4'b0000, 1'b1, "R6 drop single");
    step(4'b0100, 4'b0100, 1'b1, "R2 re-request");
    step(4'b0000, 4'b0000, 1'b1, "R1 final idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule